// File: doc/BRIEF.md
# Cascaded Lookup-Table Logic Cell

This cell is one fine-grain element of a programmable logic fabric. Two primary lookup tables of four inputs each take their selects straight from eight independent cell inputs. A third, smaller table takes the two primary results plus one more cell input. The cell can therefore act either as two unrelated four-input functions or as one function of up to nine inputs. Each of the two cell outputs picks one of the three table results, either as it is or through its own flip-flop.

All truth tables and output-select bits sit in a single shift chain. The chain loads one bit per clock while the configuration enable is high. While loading, both outputs are forced low and the flip-flops are frozen. After loading, the chain keeps its contents until the next load or reset. The flip-flops share a clock enable and a synchronous clear.

Top module: `clb_three_lut`

## Requirements
- R1: A synchronous active-low reset clears the configuration chain and both flip-flops, so after reset both outputs read 0 for any input.
- R2: While `cfg_en` is high, each rising edge shifts `cfg_din` into bit 0 of the 46-bit chain and moves every other bit up one place, so a word sent most significant bit first lands in order. The layout is: bits 45..30 are the first primary table, bits 29..14 the second primary table, bits 13..6 the combining table, bits 5..3 the select of output 1 and bits 2..0 the select of output 0.
- R3: While `cfg_en` is high, both outputs are 0 and the flip-flops keep their values.
- R4: The first primary table outputs its bit at index `lut_in[3:0]`. The second outputs its bit at index `lut_in[7:4]`.
- R5: The combining table outputs its bit at index {`ext_in`, second primary result, first primary result}, with `ext_in` as the most significant bit. This makes a nine-input function.
- R6: In a 3-bit output select, bits 1..0 choose the source: 0 is the first primary table, 1 the second, 2 the combining table and 3 a constant 0. When bit 2 is 0, the output shows the chosen source in the same cycle, without a register.
- R7: When select bit 2 is 1, output k shows flip-flop k. That flip-flop captures the chosen source on a rising edge with `ce` high, `cfg_en` low and `ff_clr` low, and the new value appears after that edge.
- R8: With `ce` low and `ff_clr` low, both flip-flops hold their values whatever the inputs do.
- R9: `ff_clr` high with `cfg_en` low clears both flip-flops at the next rising edge, even when `ce` is high.
- R10: While `cfg_en` is low, `cfg_din` is ignored and the configuration is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the chain and the flip-flops |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_en | input | 1 | Shift enable for the configuration chain |
| cfg_din | input | 1 | Serial configuration data |
| lut_in | input | 8 | Selects of the two primary tables: [3:0] first, [7:4] second |
| ext_in | input | 1 | Extra select of the combining table |
| ce | input | 1 | Shared flip-flop clock enable |
| ff_clr | input | 1 | Shared synchronous flip-flop clear |
| blk_out | output | 2 | Cell outputs 1 and 0 |

## Verification
On every cycle, the assertions check that the outputs are quiet during loading and that each loading edge shifts the chain by one place. They also check that the chain is stable when loading is off, that the flip-flops hold or clear as `ce`, `ff_clr` and `cfg_en` dictate, and that the constant-zero source really gives 0. Some behaviour is only shown by the bench scenarios: that the table bits are indexed in the stated order, that the combining table forms a nine-input function, that the source encodings pick the right table, and that a registered output changes only one edge after capture.

// File: rtl/clb_pkg.sv
// Package: shared types of the cascaded lookup-table cell.
// Assumes: one 3-bit select word per cell output.
package clb_pkg;

    // Source of an output or of a flip-flop D input
    typedef enum logic [1:0] {
        SRC_PRI0 = 2'd0,
        SRC_PRI1 = 2'd1,
        SRC_CMB  = 2'd2,
        SRC_ZERO = 2'd3
    } src_e;

    // Per-output select: registered flag above the source code
    typedef struct packed {
        logic use_reg;
        src_e src;
    } osel_t;

    localparam int OSEL_W = $bits(osel_t);

endpackage

// File: rtl/clb_lut.sv
// Module: generic K-input lookup table.
// Returns the truth-table bit addressed by the select. Purely combinational.
module clb_lut #(
    parameter int K = 4,
    localparam int T = 2 ** K
) (
    input  logic [T-1:0] truth,
    input  logic [K-1:0] sel,
    output logic         y
);

    // Read the addressed truth-table bit
    always_comb begin
        y = truth[sel];
    end

endmodule

// File: rtl/clb_cfg_chain.sv
// Module: serial configuration shift chain.
// Shifts din into bit 0 on every enabled edge; holds otherwise.
// Assumes: synchronous active-low reset clears the whole chain.
module clb_cfg_chain #(
    parameter int W = 46
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         din,
    output logic [W-1:0] q
);

    // Shift register with hold when loading is off
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (shift_en) begin
            q <= {q[W-2:0], din};
        end
    end

endmodule

// File: rtl/clb_out_slice.sv
// Module: one output path of the cell: source mux, flip-flop and output mux.
// Assumes: lut_y holds {combining, second primary, first primary} results.
// The output is forced low while loading; the flip-flop freezes then.
module clb_out_slice
    import clb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_en,
    input  logic       ce,
    input  logic       ff_clr,
    input  osel_t      sel,
    input  logic [2:0] lut_y,
    output logic       ff_q,
    output logic       y
);

    logic d_src;

    // Choose the source named by the select word
    always_comb begin
        case (sel.src)
            SRC_PRI0: d_src = lut_y[0];
            SRC_PRI1: d_src = lut_y[1];
            SRC_CMB:  d_src = lut_y[2];
            default:  d_src = 1'b0;
        endcase
    end

    // Flip-flop: reset, freeze while loading, clear, then enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ff_q <= 1'b0;
        end else if (!cfg_en) begin
            if (ff_clr) begin
                ff_q <= 1'b0;
            end else if (ce) begin
                ff_q <= d_src;
            end
        end
    end

    // Output: quiet while loading, else registered or direct source
    always_comb begin
        if (cfg_en) begin
            y = 1'b0;
        end else if (sel.use_reg) begin
            y = ff_q;
        end else begin
            y = d_src;
        end
    end

endmodule

// File: rtl/clb_three_lut.sv
// Module: cascaded lookup-table logic cell (top).
// Two PRI_K-input tables feed a 3-input combining table with one extra
// input. Two outputs, each with its own select and flip-flop. All
// configuration comes from one serial chain.
// Assumes: synchronous active-low reset; the chain layout from the MSB down is
// first table, second table, combining table, output-1 select, output-0 select.
module clb_three_lut
    import clb_pkg::*;
#(
    parameter int PRI_K = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_en,
    input  logic               cfg_din,
    input  logic [2*PRI_K-1:0] lut_in,
    input  logic               ext_in,
    input  logic               ce,
    input  logic               ff_clr,
    output logic [1:0]         blk_out
);

    localparam int NUM_PRI = 2;
    localparam int NUM_OUT = 2;
    localparam int PRI_T   = 2 ** PRI_K;
    localparam int CMB_K   = NUM_PRI + 1;
    localparam int CMB_T   = 2 ** CMB_K;
    localparam int CFG_W   = NUM_PRI * PRI_T + CMB_T + NUM_OUT * OSEL_W;
    localparam int PRI_TOP = CFG_W - PRI_T;
    localparam int CMB_LO  = NUM_OUT * OSEL_W;

    logic [CFG_W-1:0]   cfg_q;
    logic [NUM_PRI-1:0] pri_y;
    logic               cmb_y;
    logic [2:0]         lut_y;
    logic [NUM_OUT-1:0] ff_q;

    clb_cfg_chain #(.W(CFG_W)) chain_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (cfg_en),
        .din      (cfg_din),
        .q        (cfg_q)
    );

    // Primary tables: table g reads input slice g
    for (genvar g = 0; g < NUM_PRI; g++) begin : g_pri
        clb_lut #(.K(PRI_K)) lut_i (
            .truth (cfg_q[PRI_TOP - g*PRI_T +: PRI_T]),
            .sel   (lut_in[g*PRI_K +: PRI_K]),
            .y     (pri_y[g])
        );
    end

    clb_lut #(.K(CMB_K)) cmb_i (
        .truth (cfg_q[CMB_LO +: CMB_T]),
        .sel   ({ext_in, pri_y}),
        .y     (cmb_y)
    );

    // Gather results in source-code order
    always_comb begin
        lut_y = {cmb_y, pri_y};
    end

    // One output slice per cell output
    for (genvar k = 0; k < NUM_OUT; k++) begin : g_out
        clb_out_slice slice_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .cfg_en (cfg_en),
            .ce     (ce),
            .ff_clr (ff_clr),
            .sel    (osel_t'(cfg_q[k*OSEL_W +: OSEL_W])),
            .lut_y  (lut_y),
            .ff_q   (ff_q[k]),
            .y      (blk_out[k])
        );
    end

endmodule

// File: rtl/clb_three_lut_chk.sv
// Module: property checker for the cascaded lookup-table cell.
// Attached to the top with a bind statement below; observes only.
module clb_three_lut_chk #(
    parameter int PRI_K = 4,
    localparam int CFG_W = 2 * (2 ** PRI_K) + 8 + 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_en,
    input logic             cfg_din,
    input logic             ce,
    input logic             ff_clr,
    input logic [CFG_W-1:0] cfg_q,
    input logic [1:0]       ff_q,
    input logic [1:0]       blk_out
);

    AST_CFG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en |-> (blk_out == 2'b00)); // R3
    AST_FF_FROZEN_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en |=> $stable(ff_q)); // R3
    AST_SHIFT_IN: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en |=> (cfg_q[0] == $past(cfg_din))); // R2
    AST_SHIFT_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en |=> (cfg_q[CFG_W-1:1] == $past(cfg_q[CFG_W-2:0]))); // R2
    AST_CFG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> $stable(cfg_q)); // R10
    AST_FF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce && !ff_clr) |=> $stable(ff_q)); // R8
    AST_FF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_en && ff_clr) |=> (ff_q == 2'b00)); // R9
    AST_ZERO_SRC0: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_en && cfg_q[2:0] == 3'b011) |-> !blk_out[0]); // R6
    AST_ZERO_SRC1: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_en && cfg_q[5:3] == 3'b011) |-> !blk_out[1]); // R6

endmodule

bind clb_three_lut clb_three_lut_chk #(.PRI_K(PRI_K)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_en  (cfg_en),
    .cfg_din (cfg_din),
    .ce      (ce),
    .ff_clr  (ff_clr),
    .cfg_q   (cfg_q),
    .ff_q    (ff_q),
    .blk_out (blk_out)
);

// File: tb/clb_three_lut_tb.sv
// Bench for the cascaded lookup-table cell. A vector table drives the
// combinational modes; directed steps follow for reset, registers, the
// shared clear and enable, and configuration retention.
module clb_three_lut_tb_top;

    localparam int CFG_W = 46;

    typedef struct packed {
        logic [1:0] cfg_id;
        logic [7:0] din;
        logic       ext;
    } vec_t;

    // Configuration word from its fields, MSB-first layout of R2
    function automatic logic [CFG_W-1:0] mk(input logic [15:0] ta, input logic [15:0] tb,
                                            input logic [7:0] tc, input logic [2:0] s1,
                                            input logic [2:0] s0);
        return {ta, tb, tc, s1, s0};
    endfunction

    localparam logic [CFG_W-1:0] CFG_AND_MAJ = {16'h8000, 16'h6996, 8'hE8, 3'b010, 3'b000};
    localparam logic [CFG_W-1:0] CFG_BITORD  = {16'h0001, 16'hFFFE, 8'h80, 3'b010, 3'b000};
    localparam logic [CFG_W-1:0] CFG_MIX     = {16'hA5C3, 16'h1234, 8'h96, 3'b011, 3'b001};
    localparam logic [CFG_W-1:0] CFG_REG     = {16'h8000, 16'h6996, 8'hE8, 3'b110, 3'b100};
    localparam logic [CFG_W-1:0] CFGS [3] = '{CFG_AND_MAJ, CFG_BITORD, CFG_MIX};

    // Stimulus vectors; expected outputs come from the model below
    localparam vec_t VECS [8] = '{
        '{2'd0, 8'h0F, 1'b0}, '{2'd0, 8'h3F, 1'b1},
        '{2'd0, 8'h07, 1'b1}, '{2'd1, 8'h00, 1'b0},
        '{2'd1, 8'h11, 1'b1}, '{2'd1, 8'h10, 1'b1},
        '{2'd2, 8'h5A, 1'b0}, '{2'd2, 8'hE3, 1'b1}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_en = 1'b0;
    logic       cfg_din = 1'b0;
    logic [7:0] lut_in = '0;
    logic       ext_in = 1'b0;
    logic       ce = 1'b0;
    logic       ff_clr = 1'b0;
    logic [1:0] blk_out;
    int         n_chk = 0;
    int         n_bad = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    clb_three_lut dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_en  (cfg_en),
        .cfg_din (cfg_din),
        .lut_in  (lut_in),
        .ext_in  (ext_in),
        .ce      (ce),
        .ff_clr  (ff_clr),
        .blk_out (blk_out)
    );

    // Source value per R4, R5 and R6 for one output
    function automatic logic [1:0] model(input logic [CFG_W-1:0] w, input logic [7:0] d,
                                         input logic e);
        logic a, b, c;
        logic [1:0] r;
        a = w[30 + int'(d[3:0])];
        b = w[14 + int'(d[7:4])];
        c = w[6 + int'({e, b, a})];
        for (int k = 0; k < 2; k++) begin
            logic [2:0] s;
            s = (k == 1) ? w[5:3] : w[2:0];
            case (s[1:0])
                2'd0: r[k] = a;
                2'd1: r[k] = b;
                2'd2: r[k] = c;
                default: r[k] = 1'b0;
            endcase
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // Shift a word MSB first; outputs must stay low meanwhile (R3)
    task automatic load_cfg(input logic [CFG_W-1:0] w);
        @(negedge clk);
        cfg_en = 1'b1;
        for (int i = CFG_W - 1; i >= 0; i--) begin
            cfg_din = w[i];
            if (i == CFG_W / 2) begin
                #1 check("R3 outputs quiet while loading", blk_out, 2'b00);
            end
            @(negedge clk);
        end
        cfg_en = 1'b0;
        cfg_din = 1'b0;
    endtask

    task automatic finish_run;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        logic [1:0] cur;
        cur = 2'd3;
        // R1: reset state
        repeat (3) @(negedge clk);
        #1 check("R1 outputs during reset", blk_out, 2'b00);
        rst_n = 1'b1;
        lut_in = 8'hFF;
        ext_in = 1'b1;
        @(negedge clk);
        #1 check("R1 cleared configuration gives 0", blk_out, 2'b00);

        // R2 R4 R5 R6: vector walk in combinational modes
        foreach (VECS[v]) begin
            if (VECS[v].cfg_id != cur) begin
                cur = VECS[v].cfg_id;
                load_cfg(CFGS[cur]);
            end
            lut_in = VECS[v].din;
            ext_in = VECS[v].ext;
            #1 check("R2 R4 R5 R6 vector", blk_out, model(CFGS[cur], VECS[v].din, VECS[v].ext));
            @(negedge clk);
        end

        // R6: constant-zero source on both outputs
        load_cfg(mk(16'hFFFF, 16'hFFFF, 8'hFF, 3'b011, 3'b011));
        lut_in = 8'h3C;
        ext_in = 1'b1;
        #1 check("R6 constant zero source", blk_out, 2'b00);

        // R7: registered outputs, value only after the capture edge
        load_cfg(CFG_REG);
        lut_in = 8'h0F;
        ext_in = 1'b1;
        ce = 1'b1;
        #1 check("R7 no direct path before capture", blk_out, 2'b00);
        @(negedge clk);
        #1 check("R7 captured after edge", blk_out, 2'b11);

        // R8: enable low holds both flip-flops
        ce = 1'b0;
        lut_in = 8'h00;
        ext_in = 1'b0;
        @(negedge clk);
        @(negedge clk);
        #1 check("R8 hold with enable low", blk_out, 2'b11);

        // R9: clear wins over enable
        ce = 1'b1;
        ff_clr = 1'b1;
        lut_in = 8'h0F;
        ext_in = 1'b1;
        @(negedge clk);
        #1 check("R9 clear over enable", blk_out, 2'b00);
        ff_clr = 1'b0;
        @(negedge clk);
        #1 check("R7 recapture after clear", blk_out, 2'b11);

        // R10: serial data ignored while loading is off
        ce = 1'b0;
        for (int i = 0; i < 8; i++) begin
            cfg_din = i[0];
            @(negedge clk);
        end
        cfg_din = 1'b0;
        #1 check("R10 outputs kept with stray data", blk_out, 2'b11);
        ce = 1'b1;
        lut_in = 8'h00;
        ext_in = 1'b0;
        @(negedge clk);
        #1 check("R10 configuration kept", blk_out, 2'b00);

        // R3: flip-flops frozen across a load
        lut_in = 8'h0F;
        ext_in = 1'b1;
        @(negedge clk);
        load_cfg(CFG_REG);
        ce = 1'b0;
        #1 check("R3 flip-flops kept across load", blk_out, 2'b11);

        // R1: reset in mid-run clears everything
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        lut_in = 8'hFF;
        #1 check("R1 reset in mid-run", blk_out, 2'b00);

        done = 1'b1;
        finish_run();
    end

endmodule